// File: doc/BRIEF.md
# Split-Capacitor DAC Switch Driver

This block sits between the comparator of a successive-approximation converter and the bottom-plate switches of its differential capacitor DAC. Each comparator decision arrives on a one-cycle strobe, together with a flag that tells which DAC node was higher. The block turns the decision into level changes on the switch controls. On every control output, 1 selects the high reference and 0 selects the low reference. Each side of the array has nine main switches, indices 1 to 9. The five largest capacitors, indices 5 to 9, are each split into two halves, so each side also has five split-half switches.

While the sample flag is high, the block holds every switch in its sampling position and clears its decision count. Once the flag drops, the first decision strobe works on the largest split capacitor, and each later strobe works on the next capacitor down. The first five decisions each pull one split half down on the side of the higher node and raise the main switch of the opposite side. The next four decisions raise one unsplit main switch. The tenth decision is the least significant bit. It only goes into the result word. Every decision is also stored in that word, most significant bit first, and any switch that has moved stays where it is until the next sample phase.

Top module: `psplit_dac_drv`

## Requirements
- R1: While `smp_i` is high, at the next clock edge every main switch output (`sw_main_p`, `sw_main_n`) is 0, every split-half output (`sw_half_p`, `sw_half_n`) is 1, and the decision count restarts. Bit k of a main output is index k+1. Bit j of a split-half output is index j+5.
- R2: Decisions 1 to 5 act on indices 9, 8, 7, 6, 5 in that order. When `dec_pos` is 1 (positive node higher), the positive split half of that index drops to 0 and the negative main switch of that index rises to 1.
- R3: For decisions 1 to 5 with `dec_pos` at 0, the negative split half of that index drops to 0 and the positive main switch of that index rises to 1.
- R4: Decisions 6 to 9 act on indices 4, 3, 2, 1 in that order. They raise the negative main switch when `dec_pos` is 1 and the positive main switch otherwise. No split half changes.
- R5: The tenth decision changes no switch output.
- R6: `code_o` bit 9 holds decision 1, and so on down to bit 0, which holds decision 10 (the LSB). Each bit is 1 when `dec_pos` was 1. The word is all zero after a sample phase.
- R7: With no accepted strobe, including the time after the sample phase and before the first decision, all outputs hold their values.
- R8: Strobes after the tenth decision of a conversion change no output.
- R9: A strobe while `smp_i` is high has no effect, and the first strobe after the sample phase still acts on index 9.
- R10: A synchronous active-low reset (`rst_n` low at a clock edge) sets the same state as R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_i | input | 1 | Sample phase flag |
| dec_stb | input | 1 | One-cycle decision strobe |
| dec_pos | input | 1 | Decision: 1 when the positive DAC node is higher |
| sw_main_p | output | 9 | Positive-side main switch levels, bit k is index k+1 |
| sw_main_n | output | 9 | Negative-side main switch levels, bit k is index k+1 |
| sw_half_p | output | 5 | Positive-side split-half levels, bit j is index j+5 |
| sw_half_n | output | 5 | Negative-side split-half levels, bit j is index j+5 |
| code_o | output | 10 | Result word, decision 1 in bit 9 |

## Verification
The main function is driven with three decision patterns: all positive, all negative and a mixed pattern. Every output is compared after each strobe. The uniform patterns tell the two sides apart on every index: a swapped side or a wrong split half shows up at once. The mixed pattern catches an index-order or bit-order error that a uniform pattern would hide. Further tests cover strobes during sampling, extra strobes after the tenth decision, idle gaps between decisions, and a sample phase or reset in the middle of a conversion. These check that the stored state holds and that the sequence restarts at index 9.

// File: rtl/psdrv_pkg.sv
// Package: shared types and helpers for the split-capacitor DAC switch driver.
// Assumes decisions are counted from 0 (first) upward.
package psdrv_pkg;

    typedef enum logic [1:0] {
        STEP_SPLIT = 2'd0,
        STEP_PLAIN = 2'd1,
        STEP_LSB   = 2'd2,
        STEP_DONE  = 2'd3
    } step_kind_e;

    // Classifies a zero-based decision number for an array of nmain main switches
    // of which the top nsplit are split.
    function automatic step_kind_e step_kind(int unsigned s, int unsigned nsplit,
                                             int unsigned nmain);
        if (s < nsplit)     return STEP_SPLIT;
        else if (s < nmain) return STEP_PLAIN;
        else if (s == nmain) return STEP_LSB;
        else                return STEP_DONE;
    endfunction

endpackage

// File: rtl/psdrv_step_ctr.sv
// Module: decision counter. Counts accepted decision strobes from 0 to NBITS.
// Accepts a strobe only outside the sample phase and before the count saturates.
// Assumes: smp high restarts the count; reset is synchronous active-low.
module psdrv_step_ctr
    import psdrv_pkg::*;
#(
    parameter int unsigned NBITS  = 10,
    parameter int unsigned NSPLIT = 5,
    localparam int unsigned CW    = $clog2(NBITS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp,
    input  logic          dec_stb,
    output logic [CW-1:0] step,
    output logic          take,
    output step_kind_e    kind
);

    // Accept a strobe only in the conversion phase while decisions remain.
    always_comb take = dec_stb && !smp && (step < CW'(NBITS));

    // Classify the current decision number.
    always_comb kind = step_kind(int'(step), NSPLIT, NBITS - 1);

    // Count accepted decisions; restart on reset or sampling.
    always_ff @(posedge clk) begin
        if (!rst_n || smp) step <= '0;
        else if (take)     step <= step + 1'b1;
    end

    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        step <= CW'(NBITS));

    p_smp_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        smp |=> step == '0);

    p_no_take_in_smp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        smp |-> !take);

endmodule

// File: rtl/psdrv_switch_bank.sv
// Module: bottom-plate switch registers for both sides of the split DAC.
// Main cell k (index k+1) is driven by decision NMAIN-1-k. Split cell j
// (index NMAIN-NSPLIT+j+1) is driven by decision NSPLIT-1-j. Main cells only rise and
// split cells only fall until the next sample phase.
// Assumes: take is already qualified with the sample flag and decision count.
module psdrv_switch_bank
    import psdrv_pkg::*;
#(
    parameter int unsigned NMAIN  = 9,
    parameter int unsigned NSPLIT = 5,
    parameter int unsigned CW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp,
    input  logic              take,
    input  logic [CW-1:0]     step,
    input  step_kind_e        kind,
    input  logic              dec_pos,
    output logic [NMAIN-1:0]  main_p,
    output logic [NMAIN-1:0]  main_n,
    output logic [NSPLIT-1:0] half_p,
    output logic [NSPLIT-1:0] half_n
);

    for (genvar k = 0; k < NMAIN; k++) begin : g_main
        localparam int unsigned STEP_AT = NMAIN - 1 - k;
        logic hit;
        always_comb hit = take && (step == CW'(STEP_AT));

        // Raise the positive main switch when the negative node is higher.
        always_ff @(posedge clk) begin
            if (!rst_n || smp)     main_p[k] <= 1'b0;
            else if (hit && !dec_pos) main_p[k] <= 1'b1;
        end

        // Raise the negative main switch when the positive node is higher.
        always_ff @(posedge clk) begin
            if (!rst_n || smp)    main_n[k] <= 1'b0;
            else if (hit && dec_pos) main_n[k] <= 1'b1;
        end
    end

    for (genvar j = 0; j < NSPLIT; j++) begin : g_half
        localparam int unsigned STEP_AT = NSPLIT - 1 - j;
        logic hit;
        always_comb hit = take && (step == CW'(STEP_AT));

        // Drop the positive split half when the positive node is higher.
        always_ff @(posedge clk) begin
            if (!rst_n || smp)    half_p[j] <= 1'b1;
            else if (hit && dec_pos) half_p[j] <= 1'b0;
        end

        // Drop the negative split half when the negative node is higher.
        always_ff @(posedge clk) begin
            if (!rst_n || smp)     half_n[j] <= 1'b1;
            else if (hit && !dec_pos) half_n[j] <= 1'b0;
        end
    end

    p_smp_default_r1: assert property (@(posedge clk) disable iff (!rst_n)
        smp |=> (main_p == '0) && (main_n == '0) && (&half_p) && (&half_n));

    p_split_pos_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && kind == STEP_SPLIT && dec_pos) |=>
            ($countones(half_p ^ $past(half_p)) == 1) && $stable(half_n)
            && $stable(main_p) && ($countones(main_n ^ $past(main_n)) == 1));

    p_split_neg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && kind == STEP_SPLIT && !dec_pos) |=>
            ($countones(half_n ^ $past(half_n)) == 1) && $stable(half_p)
            && $stable(main_n) && ($countones(main_p ^ $past(main_p)) == 1));

    p_plain_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && kind == STEP_PLAIN) |=>
            $stable(half_p) && $stable(half_n)
            && (($countones(main_p ^ $past(main_p))
                 + $countones(main_n ^ $past(main_n))) == 1));

    p_lsb_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && kind == STEP_LSB) |=>
            $stable(main_p) && $stable(main_n) && $stable(half_p) && $stable(half_n));

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !smp) |=>
            $stable(main_p) && $stable(main_n) && $stable(half_p) && $stable(half_n));

    p_main_no_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !smp |=> ((main_p & $past(main_p)) == $past(main_p))
                 && ((main_n & $past(main_n)) == $past(main_n)));

endmodule

// File: rtl/psdrv_code_reg.sv
// Module: result word. Decision s is stored in bit NBITS-1-s, 1 meaning the
// positive node was higher. Cleared on reset and while sampling.
module psdrv_code_reg #(
    parameter int unsigned NBITS = 10,
    parameter int unsigned CW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp,
    input  logic             take,
    input  logic [CW-1:0]    step,
    input  logic             dec_pos,
    output logic [NBITS-1:0] code
);

    for (genvar b = 0; b < NBITS; b++) begin : g_bit
        localparam int unsigned STEP_AT = NBITS - 1 - b;
        // Capture the decision that belongs to this bit position.
        always_ff @(posedge clk) begin
            if (!rst_n || smp)                       code[b] <= 1'b0;
            else if (take && step == CW'(STEP_AT))   code[b] <= dec_pos;
        end
    end

    p_code_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        smp |=> code == '0);

    p_code_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !smp) |=> $stable(code));

endmodule

// File: rtl/psplit_dac_drv.sv
// Module: top of the split-capacitor DAC switch driver. Connects the decision
// counter, the switch bank and the result word.
// Assumes: one decision strobe per comparison, a sample flag that separates
// conversions, and a synchronous active-low reset.
module psplit_dac_drv
    import psdrv_pkg::*;
#(
    parameter int unsigned NBITS  = 10,
    parameter int unsigned NSPLIT = 5,
    localparam int unsigned NMAIN = NBITS - 1,
    localparam int unsigned CW    = $clog2(NBITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_i,
    input  logic              dec_stb,
    input  logic              dec_pos,
    output logic [NMAIN-1:0]  sw_main_p,
    output logic [NMAIN-1:0]  sw_main_n,
    output logic [NSPLIT-1:0] sw_half_p,
    output logic [NSPLIT-1:0] sw_half_n,
    output logic [NBITS-1:0]  code_o
);

    logic [CW-1:0] step;
    logic          take;
    step_kind_e    kind;

    psdrv_step_ctr #(.NBITS(NBITS), .NSPLIT(NSPLIT)) u_ctr (
        .clk(clk), .rst_n(rst_n), .smp(smp_i), .dec_stb(dec_stb),
        .step(step), .take(take), .kind(kind)
    );

    psdrv_switch_bank #(.NMAIN(NMAIN), .NSPLIT(NSPLIT), .CW(CW)) u_bank (
        .clk(clk), .rst_n(rst_n), .smp(smp_i), .take(take), .step(step),
        .kind(kind), .dec_pos(dec_pos),
        .main_p(sw_main_p), .main_n(sw_main_n),
        .half_p(sw_half_p), .half_n(sw_half_n)
    );

    psdrv_code_reg #(.NBITS(NBITS), .CW(CW)) u_code (
        .clk(clk), .rst_n(rst_n), .smp(smp_i), .take(take), .step(step),
        .dec_pos(dec_pos), .code(code_o)
    );

    p_ignore_late_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_stb && !smp_i && step == CW'(NBITS)) |=>
            $stable(sw_main_p) && $stable(sw_main_n) && $stable(sw_half_p)
            && $stable(sw_half_n) && $stable(code_o));

    p_pair_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_main_p & sw_main_n) == '0);

endmodule

// File: tb/psplit_dac_drv_bench.sv
// Bench: directed scenarios for the split-capacitor DAC switch driver, one task
// each, compared against a model built from the requirements.
module psplit_dac_drv_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_i = 1'b0;
    logic       dec_stb = 1'b0;
    logic       dec_pos = 1'b0;
    logic [8:0] sw_main_p, sw_main_n;
    logic [4:0] sw_half_p, sw_half_n;
    logic [9:0] code_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [8:0] e_mp, e_mn;
    logic [4:0] e_hp, e_hn;
    logic [9:0] e_code;
    int         e_step;

    psplit_dac_drv u_psplit_dac_drv (
        .clk(clk), .rst_n(rst_n), .smp_i(smp_i), .dec_stb(dec_stb), .dec_pos(dec_pos),
        .sw_main_p(sw_main_p), .sw_main_n(sw_main_n),
        .sw_half_p(sw_half_p), .sw_half_n(sw_half_n), .code_o(code_o)
    );

    always #5 clk = ~clk;

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, cycles %0d expected below 100000", cycles);
            summary();
        end
    end

    task automatic model_defaults();
        e_mp = '0; e_mn = '0; e_hp = '1; e_hn = '1; e_code = '0; e_step = 0;
    endtask

    // Decision model from R2..R6, R8.
    task automatic model_dec(input logic d);
        if (e_step < 5) begin
            if (d) begin e_hp[4 - e_step] = 1'b0; e_mn[8 - e_step] = 1'b1; end
            else   begin e_hn[4 - e_step] = 1'b0; e_mp[8 - e_step] = 1'b1; end
        end else if (e_step < 9) begin
            if (d) e_mn[8 - e_step] = 1'b1;
            else   e_mp[8 - e_step] = 1'b1;
        end
        if (e_step < 10) begin
            e_code[9 - e_step] = d;
            e_step++;
        end
    endtask

    task automatic chk(input string rtag, input string what);
        checks++;
        if ({sw_main_p, sw_main_n, sw_half_p, sw_half_n, code_o}
            !== {e_mp, e_mn, e_hp, e_hn, e_code}) begin
            errors++;
            $display("FAIL %s %s: got mp=%b mn=%b hp=%b hn=%b code=%b expected mp=%b mn=%b hp=%b hn=%b code=%b",
                     rtag, what, sw_main_p, sw_main_n, sw_half_p, sw_half_n, code_o,
                     e_mp, e_mn, e_hp, e_hn, e_code);
        end
    endtask

    task automatic do_sample(input int n);
        @(negedge clk); smp_i = 1'b1;
        repeat (n) @(negedge clk);
        smp_i = 1'b0;
        model_defaults();
    endtask

    function automatic string step_tag(input int s);
        if (s < 5)      return "R2/R3";
        else if (s < 9) return "R4";
        else if (s == 9) return "R5/R6";
        else            return "R8";
    endfunction

    task automatic do_dec(input logic d);
        string t;
        t = step_tag(e_step);
        @(negedge clk); dec_stb = 1'b1; dec_pos = d;
        @(negedge clk); dec_stb = 1'b0;
        model_dec(d);
        chk(t, "after decision");
    endtask

    task automatic run_word(input logic [9:0] w, input string name);
        do_sample(2);
        chk("R1", {name, " sample defaults"});
        for (int i = 9; i >= 0; i--) do_dec(w[i]);
        chk("R6", {name, " final word"});
    endtask

    task automatic t_reset();
        @(negedge clk); model_defaults();
        chk("R10", "reset state");
    endtask

    task automatic t_patterns();
        run_word(10'b1111111111, "all positive R2");
        run_word(10'b0000000000, "all negative R3");
        run_word(10'b1011001101, "mixed R4");
    endtask

    task automatic t_hold();
        do_sample(1);
        repeat (3) @(negedge clk);
        chk("R7", "idle before first decision");
        do_dec(1'b0);
        do_dec(1'b1);
        repeat (4) @(negedge clk);
        chk("R7", "idle between decisions");
    endtask

    task automatic t_sample_strobe();
        @(negedge clk); smp_i = 1'b1; dec_stb = 1'b1; dec_pos = 1'b1;
        repeat (3) @(negedge clk);
        dec_stb = 1'b0; smp_i = 1'b0;
        model_defaults();
        chk("R9", "strobe in sample phase");
        do_dec(1'b1);
        chk("R9", "first decision after sample hits index 9");
    endtask

    task automatic t_late();
        run_word(10'b0110100110, "late base");
        do_dec(1'b0);
        do_dec(1'b1);
        do_dec(1'b0);
        chk("R8", "strobes past the tenth");
    endtask

    task automatic t_mid_restart();
        do_sample(1);
        do_dec(1'b1); do_dec(1'b0); do_dec(1'b1); do_dec(1'b1); do_dec(1'b0); do_dec(1'b1);
        do_sample(1);
        chk("R1", "sample in mid conversion");
        do_dec(1'b1); do_dec(1'b0); do_dec(1'b0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        model_defaults();
        chk("R10", "reset in mid conversion");
        do_dec(1'b0);
        chk("R10", "sequence restarts after reset");
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_patterns();
        t_hold();
        t_sample_strobe();
        t_late();
        t_mid_restart();
        repeat (2) @(negedge clk);
        summary();
    end

endmodule